// File: doc/BRIEF.md
# Sampling Converter Host Bus Interface

This block is the digital control and bus logic of a microprocessor-compatible 12-bit sampling converter. A host selects the part with an active-high enable and an active-low select. It uses a read/convert line (high means read, low means convert) to either launch a conversion or fetch the last result. During a conversion the address line picks a short 8-bit conversion or a full 12-bit one. During a read it picks which byte of the result goes on the bus.

A conversion starts when the convert condition (enable high, select low, read/convert low) becomes true. Any of the three lines can be the one that completes it. The input word from the converter core is held at that moment. A busy flag then stays high for a fixed number of bit cycles, and the result register is loaded when the flag drops. Each of the 12 data lines is a value plus an enable. The host reads the result either as one 12-bit word or as two left-justified bytes. The byte form suits a narrow bus where data lines 3..0 are tied to lines 11..8.

Top module: `sarHostPort`

## Requirements
- R1: After reset, busy is low and all 12 data-line enables are low.
- R2: With enable low or select high, no conversion starts and no data line is enabled, whatever the other inputs do.
- R3: A conversion starts on the first clock edge where enable is high, select is low and read/convert is low, provided the previous edge did not also see that condition. A rising enable, a falling select or a falling read/convert can each complete the condition. Busy is high from the following cycle.
- R4: Busy stays high for 13 clock cycles when the address line was low at the start (12-bit conversion) and for 9 cycles when it was high (8-bit conversion). The mode is taken only at the start, so toggling the address line later has no effect.
- R5: A start condition that appears while busy is high is ignored: busy length and result are unchanged.
- R6: The result is the core input word present on the start edge. Later changes to that input do not alter it.
- R7: After an 8-bit conversion, result bits 3..0 are zero.
- R8: Data-line enables are all low unless read/convert is high, busy is low, enable is high and select is low.
- R9: A read with the word-mode input high enables all 12 lines with result bits 11..0, whatever the address line is.
- R10: A read with word mode low and address low enables lines 11..4 carrying result bits 11..4. Lines 3..0 are off.
- R11: A read with word mode low and address high enables lines 7..0. Lines 3..0 carry result bits 3..0, lines 7..4 are driven zero, and lines 11..8 are off.
- R12: In byte mode, lines 11..8 and lines 3..0 are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEn | input | 1 | Enable, active high |
| chipSelN | input | 1 | Select, active low |
| readConvN | input | 1 | 1 = read, 0 = convert |
| byteAddr | input | 1 | Short-conversion select at start; byte select when reading |
| wideMode | input | 1 | 1 = full-word read, 0 = byte read |
| sampleWord | input | 12 | Digital word from the converter core |
| busy | output | 1 | High while a conversion runs |
| dataOut | output | 12 | Data-line values (zero where not enabled) |
| dataOe | output | 12 | Per-line output enables |

## Verification
The start decoder and the busy sequencer can act in the same cycle. A new start condition can arrive while a conversion is still counting. The bench provokes this in the middle of a conversion. In one cycle it drops read/convert, changes the core input word and flips the address line. It then checks three things: the busy length still matches the mode captured at the original start, the word read back is the one held at that start, and a read attempted during the conversion keeps the bus released.

// File: rtl/sarHostPkg.sv
package sarHostPkg;
  typedef struct packed {
    logic sampleHold;   // capture the core word on this edge
    logic latchResult;  // load the result register on this edge
    logic shortConv;    // current conversion is the short one
  } ctrlStrobeT;
endpackage

// File: rtl/sarHostCtrl.sv
module sarHostCtrl
  import sarHostPkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int SHORT_W   = 8,
  parameter int SETUP_CYC = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEn,
  input  logic       chipSelN,
  input  logic       readConvN,
  input  logic       byteAddr,
  output logic       busy,
  output ctrlStrobeT strobe
);
  localparam int LONG_LEN  = WORD_W + SETUP_CYC;
  localparam int SHORT_LEN = SHORT_W + SETUP_CYC;
  localparam int CNT_W     = $clog2(LONG_LEN + 1);

  logic             armed, armedPrev, startFire;
  logic             busyReg, shortReg;
  logic [CNT_W-1:0] remain;

  assign armed     = chipEn & ~chipSelN & ~readConvN;
  assign startFire = armed & ~armedPrev & ~busyReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedPrev <= 1'b0;
      busyReg   <= 1'b0;
      shortReg  <= 1'b0;
      remain    <= '0;
    end else begin
      armedPrev <= armed;
      if (startFire) begin
        busyReg  <= 1'b1;
        shortReg <= byteAddr;
        remain   <= byteAddr ? CNT_W'(SHORT_LEN) : CNT_W'(LONG_LEN);
      end else if (busyReg) begin
        if (remain == CNT_W'(1)) busyReg <= 1'b0;
        remain <= remain - CNT_W'(1);
      end
    end
  end

  assign busy               = busyReg;
  assign strobe.sampleHold  = startFire;
  assign strobe.latchResult = busyReg && (remain == CNT_W'(1));
  assign strobe.shortConv   = shortReg;

  // checker-only run-length counter
  logic [CNT_W:0] runLen;
  always_ff @(posedge clk) begin
    if (!rstN)         runLen <= '0;
    else if (!busyReg) runLen <= '0;
    else               runLen <= runLen + 1'b1;
  end

  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !armedPrev && !busyReg) |=> busyReg);

  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busyReg && !(chipEn && !chipSelN)) |=> !busyReg);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyReg) |-> (runLen == (shortReg ? (CNT_W+1)'(SHORT_LEN) : (CNT_W+1)'(LONG_LEN))));

  p_ignore_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busyReg && armed && !armedPrev) |=> $stable(shortReg));
endmodule

// File: rtl/sarHostData.sv
module sarHostData
  import sarHostPkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [WORD_W-1:0] sampleWord,
  input  logic              chipEn,
  input  logic              chipSelN,
  input  logic              readConvN,
  input  logic              byteAddr,
  input  logic              wideMode,
  input  logic              busy,
  output logic [WORD_W-1:0] dataOut,
  output logic [WORD_W-1:0] dataOe
);
  localparam int NIB_W = WORD_W - SHORT_W;

  logic [WORD_W-1:0] holdReg, resultReg;
  logic              readEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      resultReg <= '0;
    end else begin
      if (strobe.sampleHold) holdReg <= sampleWord;
      if (strobe.latchResult)
        resultReg <= strobe.shortConv ? {holdReg[WORD_W-1:NIB_W], {NIB_W{1'b0}}} : holdReg;
    end
  end

  assign readEn = chipEn & ~chipSelN & readConvN & ~busy;

  for (genvar i = 0; i < WORD_W; i++) begin : g_line
    localparam bit IN_HI  = (i >= NIB_W);
    localparam bit IN_LO  = (i < SHORT_W);
    localparam bit HAS_LO = (i < NIB_W);
    logic lineSel;
    assign lineSel   = wideMode | (~byteAddr & IN_HI) | (byteAddr & IN_LO);
    assign dataOe[i] = readEn & lineSel;
    if (HAS_LO) begin : g_lsb
      assign dataOut[i] = dataOe[i] & resultReg[i];
    end else begin : g_msb
      assign dataOut[i] = dataOe[i] & (wideMode | ~byteAddr) & resultReg[i];
    end
  end

  p_hiz_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(chipEn && !chipSelN && readConvN && !busy) |-> (dataOe == '0));

  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rstN)
    !wideMode |-> !((|dataOe[WORD_W-1:SHORT_W]) && (|dataOe[NIB_W-1:0])));

  p_short_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchResult && strobe.shortConv) |=> (resultReg[NIB_W-1:0] == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchResult |=> (resultReg[WORD_W-1:NIB_W] == $past(holdReg[WORD_W-1:NIB_W])));
endmodule

// File: rtl/sarHostPort.sv
module sarHostPort
  import sarHostPkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int SHORT_W   = 8,
  parameter int SETUP_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              chipSelN,
  input  logic              readConvN,
  input  logic              byteAddr,
  input  logic              wideMode,
  input  logic [WORD_W-1:0] sampleWord,
  output logic              busy,
  output logic [WORD_W-1:0] dataOut,
  output logic [WORD_W-1:0] dataOe
);
  ctrlStrobeT strobe;
  logic       busyInt;

  sarHostCtrl #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .SETUP_CYC(SETUP_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .chipSelN(chipSelN),
    .readConvN(readConvN), .byteAddr(byteAddr), .busy(busyInt), .strobe(strobe)
  );

  sarHostData #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleWord(sampleWord),
    .chipEn(chipEn), .chipSelN(chipSelN), .readConvN(readConvN),
    .byteAddr(byteAddr), .wideMode(wideMode), .busy(busyInt),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  assign busy = busyInt;
endmodule

// File: tb/sarHostPort_test.sv
module sarHostPort_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipEn = 1'b0, chipSelN = 1'b1, readConvN = 1'b1;
  logic        byteAddr = 1'b0, wideMode = 1'b1;
  logic [11:0] sampleWord = 12'h000;
  logic        busy;
  logic [11:0] dataOut, dataOe;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  typedef struct { logic [11:0] oe; logic [11:0] data; string tag; } expT;
  expT expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  sarHostPort uut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .chipSelN(chipSelN),
    .readConvN(readConvN), .byteAddr(byteAddr), .wideMode(wideMode),
    .sampleWord(sampleWord), .busy(busy), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  // monitor: pops expected bus states and compares them at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expT it;
      it = expQ.pop_front();
      chk(dataOe == it.oe, {it.tag, " enables"}, int'(dataOe), int'(it.oe));
      chk((dataOut & dataOe) == (it.data & it.oe), {it.tag, " data"},
          int'(dataOut & dataOe), int'(it.data & it.oe));
      if (!wideMode)
        chk(!((|dataOe[11:8]) && (|dataOe[3:0])), "R12 byte groups overlap", int'(dataOe), 0);
    end
  end

  task automatic readBus(input logic ce, input logic csn, input logic w, input logic a0,
                         input logic [11:0] eo, input logic [11:0] ed, input string tag);
    @(posedge clk); #2;
    chipEn = ce; chipSelN = csn; readConvN = 1'b1; wideMode = w; byteAddr = a0;
    expQ.push_back('{eo, ed, tag});
    @(negedge clk); #1;
  endtask

  // caller has applied the completing edge at posedge+2
  task automatic convRun(input int expLen, input string tag, input bit poke, input logic [11:0] pokeWord);
    int cnt;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
    cnt = 1;
    #1 readConvN = 1'b1;
    forever begin
      @(negedge clk);
      if (!busy || cnt > 64) break;
      cnt++;
      #1;
      if (poke && cnt == 3) begin
        sampleWord = pokeWord; readConvN = 1'b0; byteAddr = ~byteAddr;
      end
      if (poke && cnt == 4) begin
        readConvN = 1'b1;
        expQ.push_back('{12'h000, 12'h000, "R8 read while busy"});
      end
    end
    chk(cnt == expLen, tag, cnt, expLen);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(dataOe == 12'h000, "R1 enables after reset", int'(dataOe), 0);

    // start by read/convert falling, 12-bit, with mid-conversion disturbance
    @(posedge clk); #2;
    chipEn = 1'b1; chipSelN = 1'b0; readConvN = 1'b1; byteAddr = 1'b0; sampleWord = 12'hABC;
    @(posedge clk); #2 readConvN = 1'b0;
    convRun(13, "R4 R5 12-bit length", 1'b1, 12'h123);
    readBus(1, 0, 1, 0, 12'hFFF, 12'hABC, "R6 R9 word read");
    readBus(1, 0, 1, 1, 12'hFFF, 12'hABC, "R9 word read A0 high");
    readBus(1, 0, 0, 0, 12'hFF0, 12'hAB0, "R10 high byte");
    readBus(1, 0, 0, 1, 12'h0FF, 12'h00C, "R11 low byte");
    readBus(0, 0, 1, 0, 12'h000, 12'h000, "R2 enable low read");
    readBus(1, 1, 0, 0, 12'h000, 12'h000, "R2 select high read");

    // gated start attempt: enable low
    @(posedge clk); #2 chipEn = 1'b0; chipSelN = 1'b0; readConvN = 1'b1;
    @(posedge clk); #2 readConvN = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R2 no start with enable low", int'(busy), 0);
    @(negedge clk);
    chk(busy == 1'b0, "R2 still idle", int'(busy), 0);

    // start by enable rising, 8-bit
    #1 byteAddr = 1'b1; sampleWord = 12'h5A7;
    @(posedge clk); #2 chipEn = 1'b1;
    convRun(9, "R3 R4 8-bit length via enable", 1'b0, 12'h000);
    readBus(1, 0, 1, 0, 12'hFFF, 12'h5A0, "R7 word after short conv");
    readBus(1, 0, 0, 1, 12'h0FF, 12'h000, "R7 R11 low byte after short conv");

    // start by select falling, 12-bit, address toggled mid-conversion
    @(posedge clk); #2;
    chipEn = 1'b1; chipSelN = 1'b1; readConvN = 1'b0; byteAddr = 1'b0; sampleWord = 12'hF0F;
    @(posedge clk); #2 chipSelN = 1'b0;
    convRun(13, "R3 R4 R5 length via select", 1'b1, 12'h000);
    readBus(1, 0, 1, 0, 12'hFFF, 12'hF0F, "R5 R6 word after select start");
    readBus(1, 0, 0, 0, 12'hFF0, 12'hF00, "R10 high byte second");
    readBus(1, 0, 0, 1, 12'h0FF, 12'h00F, "R11 R12 low byte second");

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule